// File: doc/BRIEF.md
# Scan Line Address Generator

This block supplies the memory row (bit-slice) address that the segment drivers read during display refresh. A field-start pulse loads an origin line, and each line-advance pulse moves the address one step through a space of 80 lines that wraps at both ends. The direction of travel and the origin come from a start-line setting, a row-mirror bit and a multiplex-ratio setting.

Changing the start line between fields scrolls the image. Setting the row mirror reverses the line order, which flips the image vertically. The scan order of the common electrodes and the stored memory contents are left unchanged. All three settings are captured on the field-start pulse and held until the next one.

The control is a two-state machine.
- `ST_IDLE` follows reset. In this state the address is held at 0 and advance pulses are ignored.
- Transition `T_ARM` moves the machine from `ST_IDLE` to `ST_SCAN` on a field start.
- In `ST_SCAN`, transition `T_RESTART` (a field start) reloads the origin.
- `T_STEP` (an advance pulse) moves the address by one line.
- `T_HOLD` (no pulse) keeps the address where it is.

Top module: `scan_line_gen`

## Requirements
- R1: After reset `line_addr` is 0 and `scan_active` is 0. Advance pulses before the first field start leave `line_addr` at 0.
- R2: `line_addr` always lies in the range 0 to 79.
- R3: With `row_mirror` = 0 at a field start, the next cycle shows `line_addr` equal to the start line.
- R4: While the field was started with the mirror off, each advance pulse adds 1 to the address, and 79 is followed by 0.
- R5: With `row_mirror` = 1 at a field start, the next cycle shows `line_addr` = (start line + `mux_ratio`) mod 80. Here `mux_ratio` holds the multiplex count minus one.
- R6: While the field was started with the mirror on, each advance pulse subtracts 1 from the address, and 0 is followed by 79.
- R7: Changes to `start_line`, `row_mirror` or `mux_ratio` after a field start have no effect until the next field start.
- R8: A `start_line` or `mux_ratio` value above 79 is used as 79.
- R9: A field start and an advance pulse in the same cycle act as a field start alone.
- R10: In a cycle with neither pulse, `line_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| line_adv | input | 1 | One-cycle pulse at each later line period |
| start_line | input | 7 | Scroll origin line |
| row_mirror | input | 1 | 1 reverses the line order |
| mux_ratio | input | 7 | Multiplex count minus one |
| line_addr | output | 7 | Current memory line address |
| scan_active | output | 1 | 1 once the first field has started |

## Verification
Plain scrolling is tested with origins 0, 5 and 78, so that a run of advances crosses the 79-to-0 wrap. Mirrored fields use several combinations of start line and multiplex ratio. One of these sums to 80 or more, which separates a correct modulo reduction from plain addition. Another sets both settings to zero, which shows the downward wrap from 0 to 79 on the first step. Further tests change the settings in the middle of a field, give out-of-range values, and drive both pulses in the same cycle. Together these separate sampled settings from live ones, clamping from truncation, and the correct pulse priority from the wrong one.

// File: rtl/slg_pkg.sv
package slg_pkg;
    localparam int unsigned SLG_LINES = 80;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } slg_state_e;
endpackage

// File: rtl/slg_origin.sv
module slg_origin #(
    parameter int unsigned LINES = 80,
    parameter int unsigned AW    = $clog2(LINES)
) (
    input  logic [AW-1:0] sl,
    input  logic [AW-1:0] mux,
    input  logic          mirror,
    output logic [AW-1:0] origin
);
    localparam logic [AW-1:0] LAST  = AW'(LINES - 1);
    localparam logic [AW:0]   MODV  = (AW+1)'(LINES);

    logic [AW-1:0] sl_c;
    logic [AW-1:0] mux_c;
    logic [AW:0]   sum;

    always_comb begin
        sl_c  = (sl  > LAST) ? LAST : sl;
        mux_c = (mux > LAST) ? LAST : mux;
        sum   = {1'b0, sl_c} + {1'b0, mux_c};
        if (mirror) begin
            origin = (sum >= MODV) ? AW'(sum - MODV) : AW'(sum);
        end else begin
            origin = sl_c;
        end
    end
endmodule

// File: rtl/slg_step.sv
module slg_step #(
    parameter int unsigned LINES = 80,
    parameter int unsigned AW    = $clog2(LINES)
) (
    input  logic [AW-1:0] cur,
    input  logic          down,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] LAST = AW'(LINES - 1);

    always_comb begin
        if (down) begin
            nxt = (cur == '0) ? LAST : cur - AW'(1);
        end else begin
            nxt = (cur >= LAST) ? '0 : cur + AW'(1);
        end
    end
endmodule

// File: rtl/scan_line_gen.sv
module scan_line_gen #(
    parameter int unsigned LINES = slg_pkg::SLG_LINES,
    parameter int unsigned AW    = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_start,
    input  logic          line_adv,
    input  logic [AW-1:0] start_line,
    input  logic          row_mirror,
    input  logic [AW-1:0] mux_ratio,
    output logic [AW-1:0] line_addr,
    output logic          scan_active
);
    import slg_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(LINES - 1);

    slg_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          down_q;
    logic [AW-1:0] origin;
    logic [AW-1:0] stepped;

    slg_origin #(.LINES(LINES), .AW(AW)) u_origin (
        .sl     (start_line),
        .mux    (mux_ratio),
        .mirror (row_mirror),
        .origin (origin)
    );

    slg_step #(.LINES(LINES), .AW(AW)) u_step (
        .cur  (addr_q),
        .down (down_q),
        .nxt  (stepped)
    );

    // next state: T_ARM / T_RESTART / T_STEP / T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = field_start ? ST_SCAN : ST_IDLE;
            ST_SCAN: state_d = ST_SCAN;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            down_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (field_start) begin
                        addr_q <= origin;
                        down_q <= row_mirror;
                    end
                end
                ST_SCAN: begin
                    if (field_start) begin
                        addr_q <= origin;
                        down_q <= row_mirror;
                    end else if (line_adv) begin
                        addr_q <= stepped;
                    end
                end
                default: begin
                    addr_q <= '0;
                end
            endcase
        end
    end

    assign line_addr   = addr_q;
    assign scan_active = (state_q == ST_SCAN);

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_addr <= LAST);

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_active |-> line_addr == '0);

    assert_plain_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && !row_mirror && start_line <= LAST) |=> line_addr == $past(start_line));

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_active && line_adv && !field_start && !down_q) |=>
        line_addr == (($past(line_addr) == LAST) ? '0 : $past(line_addr) + AW'(1)));

    assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_active && line_adv && !field_start && down_q) |=>
        line_addr == (($past(line_addr) == '0) ? LAST : $past(line_addr) - AW'(1)));

    assert_dir_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(down_q));

    assert_no_pulse_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_start && !line_adv) |=> $stable(line_addr));
endmodule

// File: tb/scan_line_gen_test.sv
module scan_line_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       field_start = 1'b0;
    logic       line_adv = 1'b0;
    logic [6:0] start_line = '0;
    logic       row_mirror = 1'b0;
    logic [6:0] mux_ratio = '0;
    logic [6:0] line_addr;
    logic       scan_active;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    scan_line_gen uut (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_adv(line_adv),
        .start_line(start_line), .row_mirror(row_mirror), .mux_ratio(mux_ratio),
        .line_addr(line_addr), .scan_active(scan_active)
    );

    function automatic int clampv(int v);
        return (v > 79) ? 79 : v;
    endfunction

    function automatic int origin_of(int sl, int mx, bit mir);
        if (mir) return (clampv(sl) + clampv(mx)) % 80;
        return clampv(sl);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(bit fs, bit la);
        field_start = fs;
        line_adv    = la;
        @(negedge clk);
        field_start = 1'b0;
        line_adv    = 1'b0;
    endtask

    task automatic start_field(int sl, int mx, bit mir);
        start_line = 7'(sl);
        mux_ratio  = 7'(mx);
        row_mirror = mir;
        pulse(1'b1, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1", int'(line_addr), 0);
        chk("R1", int'(scan_active), 0);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        chk("R1", int'(line_addr), 0);
    endtask

    task automatic t_plain;
        int sls[3] = '{0, 5, 78};
        foreach (sls[i]) begin
            int exp;
            start_field(sls[i], 20, 1'b0);
            exp = sls[i];
            chk("R3", int'(line_addr), exp);
            for (int k = 0; k < 4; k++) begin
                pulse(1'b0, 1'b1);
                exp = (exp + 1) % 80;
                chk("R4", int'(line_addr), exp);
                chk("R2", int'(line_addr < 80), 1);
            end
        end
    endtask

    task automatic t_mirror;
        int sl[3] = '{0, 10, 0};
        int mx[3] = '{63, 79, 0};
        foreach (sl[i]) begin
            int exp;
            start_field(sl[i], mx[i], 1'b1);
            exp = origin_of(sl[i], mx[i], 1'b1);
            chk("R5", int'(line_addr), exp);
            for (int k = 0; k < 3; k++) begin
                pulse(1'b0, 1'b1);
                exp = (exp + 79) % 80;
                chk("R6", int'(line_addr), exp);
            end
        end
    endtask

    task automatic t_midfield;
        int exp;
        start_field(40, 10, 1'b0);
        exp = 40;
        row_mirror = 1'b1;
        start_line = 7'd3;
        mux_ratio  = 7'd50;
        pulse(1'b0, 1'b1);
        exp = 41;
        chk("R7", int'(line_addr), exp);
        pulse(1'b0, 1'b1);
        chk("R7", int'(line_addr), 42);
        pulse(1'b1, 1'b0);
        chk("R7", int'(line_addr), origin_of(3, 50, 1'b1));
    endtask

    task automatic t_clamp;
        start_field(100, 127, 1'b1);
        chk("R8", int'(line_addr), 78);
        start_field(127, 0, 1'b0);
        chk("R8", int'(line_addr), 79);
        pulse(1'b0, 1'b1);
        chk("R8", int'(line_addr), 0);
    endtask

    task automatic t_collide;
        start_field(30, 0, 1'b0);
        pulse(1'b0, 1'b1);
        chk("R9", int'(line_addr), 31);
        start_line = 7'd12;
        pulse(1'b1, 1'b1);
        chk("R9", int'(line_addr), 12);
    endtask

    task automatic t_hold;
        start_field(7, 0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R10", int'(line_addr), 7);
        chk("R10", int'(scan_active), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_mirror();
        t_midfield();
        t_clamp();
        t_collide();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule